// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side read path of a word-addressed memory that serves synchronous burst reads. The host holds chip enable high and pulses an address-valid strobe together with a start address. On that rising edge the block captures the address and its read-timing configuration, counts off a programmable initial latency, and then streams consecutive words from its internal array, one per clock, for as long as chip enable stays high.

A ready output tells the host when a word is valid. The ready output is either coincident with the data or one cycle ahead of it, chosen per burst. If the start address is not aligned to a 4-word position, the sequencer pauses the stream for a few cycles the first time the burst crosses into the next 8-word range, and it drops ready for those cycles. Deasserting chip enable ends the burst. A fresh strobe restarts it at a new address.

The internal array is a synchronous-read memory whose contents are computed from the address, so a host can predict every word.

Top module: `burst_read_seq`

## Requirements
- R1: With `rdy_same_i`=1 latched, the first word and the first high `rdy_o` appear in the cycle after the W-th rising edge that follows the strobe edge. W is `wait_cfg_i` for values 2 to 7; values 0 and 1 act as 2.
- R2: With `rdy_same_i`=0 latched, `rdy_o` is high in each cycle that directly precedes a cycle carrying a valid word. The first word still arrives after edge W, so ready first rises after edge W-1.
- R3: Words are delivered in ascending address order, starting at the latched address with no alignment of the start. The address wraps from the top of the array to 0.
- R4: The word at address a equals the low DATA_W bits of (a * 0x9E3779B1) xor 0x5A5AC3C3, computed in 32-bit arithmetic.
- R5: Let s be the start address, with offset o = s mod 4. After the word whose address mod 8 is 7 has been delivered for the first time in the burst, the stream pauses for o cycles. During the pause `data_o` holds that word and the ready schedule of R1/R2 shows the gap. Offset 0 gives no pause, and later crossings in the same burst give none.
- R6: If `ce_i` is sampled low, `rdy_o` is low from the next cycle on. The burst does not resume when `ce_i` returns high without a new strobe.
- R7: `data_oe_o` is the value of `ce_i` and `oe_i` sampled together on the previous rising edge. `oe_i` does not affect `rdy_o` or the stream. After reset `data_oe_o` and `rdy_o` are low.
- R8: A strobe sampled with `ce_i` high during a burst abandons that burst. A new burst starts at the new address with the full latency of R1/R2 and no early ready.
- R9: `wait_cfg_i` and `rdy_same_i` are latched at the strobe edge. Changing them later in the burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| addr_strobe_i | input | 1 | Address-valid strobe, active high |
| oe_i | input | 1 | Output enable, active high |
| addr_i | input | ADDR_W | Burst start word address |
| wait_cfg_i | input | CFG_W | Initial latency in clocks (2..7) |
| rdy_same_i | input | 1 | 1: ready coincident with data; 0: ready one cycle early |
| data_o | output | DATA_W | Read data |
| data_oe_o | output | 1 | High when the data bus is driven; low means high-impedance |
| rdy_o | output | 1 | Data-valid indication |

## Verification
Each burst is timed from its strobe edge, counted as edge 0. The bench samples at the falling edge after edge k and compares it against a schedule it builds from R1 and R5. That schedule has the first word at k=W and a gap of s mod 4 cycles after the first word ending in 7. Ready is expected at k in same mode and at k-1 in early mode. The first cycle with ready high is also checked against W or W-1 for every latency and both modes. Chip enable and output enable results are due one edge after the input changes, so they are sampled at the very next falling edge.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_BURST,
    ST_STALL
  } seq_state_e;

  localparam logic [31:0] MIX_MUL = 32'h9E37_79B1;
  localparam logic [31:0] MIX_XOR = 32'h5A5A_C3C3;

  // computed array contents
  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * MIX_MUL) ^ MIX_XOR;
  endfunction

endpackage

// File: rtl/burst_array.sv
`timescale 1ns/1ps
module burst_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import burst_seq_pkg::*;

  logic [31:0]       word_full;
  logic [DATA_W-1:0] data_q;

  always_comb word_full = word_of(32'(rd_addr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_en_i) data_q <= word_full[DATA_W-1:0];
  end

  assign rd_data_o = data_q;

endmodule

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int CFG_W    = 3,
  parameter int MIN_WAIT = 2,
  parameter int GRP_W    = 3,
  parameter int OFF_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wait_cfg_i,
  input  logic              rdy_same_i,
  output logic              issue_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              same_o,
  output logic              restart_o
);
  import burst_seq_pkg::*;

  localparam logic [CFG_W-1:0] WAIT_FLOOR = CFG_W'(MIN_WAIT);
  localparam logic [CFG_W-1:0] ONE        = CFG_W'(1);
  localparam logic [GRP_W-1:0] GRP_LAST   = '1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CFG_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  off_q;
  logic              crossed_q;
  logic              issue_q;
  logic              same_q;
  logic              strobe_hit;
  logic [CFG_W-1:0]  eff_wait;
  logic              at_cross;

  assign strobe_hit = ce_i & strobe_i;
  assign eff_wait   = (wait_cfg_i < WAIT_FLOOR) ? WAIT_FLOOR : wait_cfg_i;
  assign at_cross   = (ptr_q[GRP_W-1:0] == GRP_LAST) && (off_q != '0) && !crossed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      cnt_q     <= '0;
      off_q     <= '0;
      crossed_q <= 1'b0;
      issue_q   <= 1'b0;
      same_q    <= 1'b1;
    end else if (!ce_i) begin
      state_q <= ST_IDLE;
      issue_q <= 1'b0;
    end else if (strobe_hit) begin
      state_q   <= ST_LAT;
      ptr_q     <= addr_i;
      cnt_q     <= eff_wait - ONE;
      off_q     <= addr_i[OFF_W-1:0];
      crossed_q <= 1'b0;
      issue_q   <= 1'b0;
      same_q    <= rdy_same_i;
    end else begin
      unique case (state_q)
        ST_LAT: begin
          if (cnt_q == ONE) begin
            issue_q <= 1'b1;
            state_q <= ST_BURST;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_BURST: begin
          if (issue_q) begin
            ptr_q <= ptr_q + ADDR_W'(1);
            if (at_cross) begin
              issue_q   <= 1'b0;
              cnt_q     <= CFG_W'(off_q);
              crossed_q <= 1'b1;
              state_q   <= ST_STALL;
            end
          end
        end
        ST_STALL: begin
          if (cnt_q == ONE) begin
            issue_q <= 1'b1;
            state_q <= ST_BURST;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: issue_q <= 1'b0;
      endcase
    end
  end

  assign issue_o   = issue_q;
  assign ptr_o     = ptr_q;
  assign same_o    = same_q;
  assign restart_o = strobe_hit;

  p_abort_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (state_q == ST_IDLE) && !issue_q);

  p_ptr_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_q && ce_i && !strobe_i) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  p_stall_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL) |-> (off_q != '0) && crossed_q && !issue_q);

  p_lat_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LAT) |-> (cnt_q >= ONE) && !issue_q);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_hit |=> (state_q == ST_LAT) && !issue_q && !crossed_q);

endmodule

// File: rtl/burst_ready.sv
`timescale 1ns/1ps
module burst_ready (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic oe_i,
  input  logic strobe_hit_i,
  input  logic issue_i,
  input  logic same_i,
  output logic rdy_o,
  output logic data_oe_o
);

  logic valid_q;
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      valid_q <= issue_i & ce_i & ~strobe_hit_i;
      oe_q    <= ce_i & oe_i;
    end
  end

  // early mode shows the fetch one cycle ahead of its data
  assign rdy_o     = same_i ? valid_q : issue_i;
  assign data_oe_o = oe_q;

  p_oe_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !data_oe_o && !rdy_o);

  p_early_lead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!same_i && rdy_o && ce_i && !strobe_hit_i) |=> valid_q);

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CFG_W    = 3,
  parameter int MIN_WAIT = 2,
  parameter int GRP_W    = 3,
  parameter int OFF_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              addr_strobe_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wait_cfg_i,
  input  logic              rdy_same_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_o
);

  logic              issue;
  logic [ADDR_W-1:0] ptr;
  logic              same;
  logic              restart;

  burst_ctrl #(
    .ADDR_W  (ADDR_W),
    .CFG_W   (CFG_W),
    .MIN_WAIT(MIN_WAIT),
    .GRP_W   (GRP_W),
    .OFF_W   (OFF_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .strobe_i  (addr_strobe_i),
    .addr_i    (addr_i),
    .wait_cfg_i(wait_cfg_i),
    .rdy_same_i(rdy_same_i),
    .issue_o   (issue),
    .ptr_o     (ptr),
    .same_o    (same),
    .restart_o (restart)
  );

  burst_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (issue),
    .rd_addr_i(ptr),
    .rd_data_o(data_o)
  );

  burst_ready u_ready (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_i),
    .oe_i        (oe_i),
    .strobe_hit_i(restart),
    .issue_i     (issue),
    .same_i      (same),
    .rdy_o       (rdy_o),
    .data_oe_o   (data_oe_o)
  );

endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;

  localparam int AW   = 8;
  localparam int DW   = 16;
  localparam int CW   = 3;
  localparam int SLOT = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic          strobe = 1'b0;
  logic          oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wait_cfg = 3'd2;
  logic          rdy_same = 1'b1;
  logic [DW-1:0] data;
  logic          data_oe;
  logic          rdy;

  int n_chk = 0;
  int n_err = 0;

  bit            ev [0:SLOT];
  logic [AW-1:0] ea [0:SLOT];

  always #4 clk = ~clk;

  burst_read_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ce_i         (ce),
    .addr_strobe_i(strobe),
    .oe_i         (oe),
    .addr_i       (addr),
    .wait_cfg_i   (wait_cfg),
    .rdy_same_i   (rdy_same),
    .data_o       (data),
    .data_oe_o    (data_oe),
    .rdy_o        (rdy)
  );

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    logic [31:0] t;
    t = ({24'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    return t[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_sched(input logic [AW-1:0] a, input int w);
    int k;
    logic [AW-1:0] p;
    bit crossed;
    int o;
    for (int i = 0; i <= SLOT; i++) begin ev[i] = 1'b0; ea[i] = '0; end
    k = w; p = a; crossed = 1'b0; o = int'(a[1:0]);
    while (k <= SLOT) begin
      ev[k] = 1'b1;
      ea[k] = p;
      if (p[2:0] == 3'd7 && o != 0 && !crossed) begin
        k = k + o + 1;
        crossed = 1'b1;
      end else begin
        k = k + 1;
      end
      p = p + 8'd1;
    end
  endtask

  task automatic go_idle();
    ce = 1'b0; strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // caller is at a falling edge; strobe edge is k=0
  task automatic run_burst(input logic [AW-1:0] a, input logic [CW-1:0] wcfg,
                           input bit same, input int ncyc, input bit poke,
                           input string req);
    int weff;
    int first;
    bit have_last;
    logic [DW-1:0] last;
    bit exp_r;
    weff = (wcfg < 3'd2) ? 2 : int'(wcfg);
    build_sched(a, weff);
    ce = 1'b1; oe = 1'b1; strobe = 1'b1; addr = a; wait_cfg = wcfg; rdy_same = same;
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0;
    if (poke) begin
      wait_cfg = (wcfg == 3'd7) ? 3'd2 : 3'd7;
      rdy_same = ~same;
    end
    first = -1; have_last = 1'b0; last = '0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      exp_r = same ? ev[k] : ev[k+1];
      chk(rdy == exp_r, req, $sformatf("ready at k=%0d", k), 32'(rdy), 32'(exp_r));
      if (rdy && first < 0) first = k;
      if (ev[k]) begin
        chk(data == exp_word(ea[k]), req, $sformatf("word at k=%0d", k),
            32'(data), 32'(exp_word(ea[k])));
        last = exp_word(ea[k]);
        have_last = 1'b1;
      end else if (have_last) begin
        chk(data == last, req, $sformatf("held word at k=%0d", k), 32'(data), 32'(last));
      end
    end
    chk(first == (same ? weff : weff - 1), req, "first ready cycle",
        32'(first), 32'(same ? weff : weff - 1));
    wait_cfg = wcfg; rdy_same = same;
  endtask

  task automatic t_reset();
    chk(rdy == 1'b0, "R7", "ready after reset", 32'(rdy), 32'd0);
    chk(data_oe == 1'b0, "R7", "bus enable after reset", 32'(data_oe), 32'd0);
  endtask

  task automatic t_latency();
    for (int w = 2; w <= 7; w++) begin
      for (int s = 0; s <= 1; s++) begin
        go_idle();
        run_burst(8'h10, 3'(w), s[0], 16, 1'b0, s[0] ? "R1 R3 R4" : "R2 R3 R4");
      end
    end
  endtask

  task automatic t_clamp();
    go_idle();
    run_burst(8'h30, 3'd0, 1'b1, 8, 1'b0, "R1 clamp");
    go_idle();
    run_burst(8'h30, 3'd1, 1'b0, 8, 1'b0, "R1 clamp");
  endtask

  task automatic t_stall();
    logic [AW-1:0] starts [6] = '{8'h41, 8'h42, 8'h43, 8'h45, 8'h44, 8'h1C};
    foreach (starts[i]) begin
      for (int s = 0; s <= 1; s++) begin
        go_idle();
        run_burst(starts[i], 3'd4, s[0], 24, 1'b0, "R5");
      end
    end
    go_idle();
    run_burst(8'hFB, 3'd3, 1'b1, 16, 1'b0, "R3 R5 wrap");
  endtask

  task automatic t_abort();
    go_idle();
    run_burst(8'h50, 3'd3, 1'b1, 6, 1'b0, "R6");
    ce = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0, "R6", "ready after abort", 32'(rdy), 32'd0);
    chk(data_oe == 1'b0, "R6", "bus enable after abort", 32'(data_oe), 32'd0);
    ce = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rdy == 1'b0, "R6", "no resume without strobe", 32'(rdy), 32'd0);
    end
  endtask

  task automatic t_oe();
    go_idle();
    run_burst(8'h60, 3'd2, 1'b1, 6, 1'b0, "R7");
    chk(data_oe == 1'b1, "R7", "bus enable while streaming", 32'(data_oe), 32'd1);
    oe = 1'b0;
    @(negedge clk);
    chk(data_oe == 1'b0, "R7", "bus enable with oe low", 32'(data_oe), 32'd0);
    chk(rdy == 1'b1, "R7", "ready unaffected by oe", 32'(rdy), 32'd1);
    chk(data == exp_word(8'h65), "R7", "stream unaffected by oe", 32'(data),
        32'(exp_word(8'h65)));
    oe = 1'b1;
    @(negedge clk);
    chk(data_oe == 1'b1, "R7", "bus enable restored", 32'(data_oe), 32'd1);
  endtask

  task automatic t_restart();
    go_idle();
    run_burst(8'h70, 3'd3, 1'b1, 6, 1'b0, "R8 first");
    run_burst(8'h91, 3'd5, 1'b0, 20, 1'b0, "R8 restart");
    run_burst(8'h22, 3'd2, 1'b1, 14, 1'b0, "R8 restart");
  endtask

  task automatic t_cfg_hold();
    go_idle();
    run_burst(8'h0B, 3'd3, 1'b1, 18, 1'b1, "R9");
    go_idle();
    run_burst(8'hA6, 3'd6, 1'b0, 20, 1'b1, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_clamp();
    t_stall();
    t_abort();
    t_oe();
    t_restart();
    t_cfg_hold();
    go_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule